// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block decides which interrupt condition of a 16550-style serial controller is reported to software. It also forms the byte that software reads from the identification register. The receiver, the transmit path, the FIFOs and the modem-line logic live elsewhere. They give this block level flags and one-cycle event pulses, and they pass on the strobes for the register accesses that clear a source. The block returns the identification byte and an active-high interrupt request.

Four enable bits decide which sources may be reported:
- bit 0: received data, together with the character timeout
- bit 1: transmitter empty
- bit 2: line-status error
- bit 3: modem-line change

The line-status, timeout and modem-change events are held in sticky flags until their clearing access arrives. A masked source is kept pending, but it stays hidden while it is masked. The transmitter-empty source is armed when the gated condition `thr_empty & int_en[1]` goes from 0 to 1. It is disarmed by a write of a new character. It is also disarmed by a read of the identification register, but only in a cycle where that source is the one shown.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source pending, `ident` reads 0x01 and `irq` is low.
- R2: The low nibble of `ident` reports the selected source with these codes: 0x6 line-status error, 0x4 received data, 0xC character timeout, 0x2 transmitter empty, 0x0 modem change. Bit 0 is 1 only when no source is reported.
- R3: Priority from highest to lowest is line status, then received data, then timeout, then transmitter empty, then modem change. Received data and timeout share one level, and received data is shown in preference to timeout.
- R4: A source whose enable bit is clear never appears in `ident`, even when its flag is set. The enable bits in `int_en` are: bit 0 received data and timeout, bit 1 transmitter empty, bit 2 line status, bit 3 modem change.
- R5: Bits 7:6 of `ident` read 11 when `fifo_en` is high and 00 otherwise. Bit 5 reads 1 only when both `fifo_en` and `fifo64_en` are high. Bit 4 is always 0.
- R6: The transmitter-empty source is armed on a 0-to-1 change of `thr_empty & int_en[1]`. A read strobe of `ident` in a cycle where code 0x2 is shown clears it by the next cycle.
- R7: A write strobe of the holding register clears the transmitter-empty source by the next cycle.
- R8: A read strobe of `ident` while a source other than transmitter empty is shown leaves the transmitter-empty source pending.
- R9: A line-status event stays reported until the line-status read strobe.
- R10: The received-data source follows `rx_ready` as a level. A timeout event stays pending until the receive-buffer read strobe.
- R11: A modem-change event stays pending until the modem-status read strobe. A read of `ident` does not clear it.
- R12: `irq` is high exactly when bit 0 of `ident` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 4 | Source enable bits |
| lsr_err_evt | input | 1 | Line-status error event pulse |
| rx_ready | input | 1 | Receive data at trigger level (level) |
| cto_evt | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_chg_evt | input | 1 | Modem-line change event pulse |
| fifo_en | input | 1 | FIFOs enabled |
| fifo64_en | input | 1 | 64-byte FIFO mode |
| rd_ident | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| wr_thr | input | 1 | Holding register write strobe |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case is an identification read that must not clear the transmitter-empty source. This needs all five sources pending at once, so the higher-priority sources hide the lower ones. The stimulus first arms the transmitter-empty source, then adds a modem change, received data, a timeout and a line-status error. It reads the identification register while the line-status code is shown. It then removes the sources one at a time through their own clearing strobes, so each lower source must come back into view in priority order. The transmitter-empty code must reappear before any identification read made while it is shown.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] int_en,
  input  logic       lsr_err_evt,
  input  logic       rx_ready,
  input  logic       cto_evt,
  input  logic       thr_empty,
  input  logic       msr_chg_evt,
  input  logic       fifo_en,
  input  logic       fifo64_en,
  input  logic       rd_ident,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       rd_msr,
  input  logic       wr_thr,
  output logic [7:0] ident,
  output logic       irq
);
  logic       ls_q, to_q, ms_q, tx_q, tx_arm_q;
  logic [3:0] code;

  wire tx_arm = thr_empty & int_en[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q     <= 1'b0;
      to_q     <= 1'b0;
      ms_q     <= 1'b0;
      tx_q     <= 1'b0;
      tx_arm_q <= 1'b0;
    end else begin
      tx_arm_q <= tx_arm;
      if (wr_thr || (rd_ident && code == 4'h2)) tx_q <= 1'b0;
      else if (tx_arm && !tx_arm_q)             tx_q <= 1'b1;
      if (lsr_err_evt)  ls_q <= 1'b1;
      else if (rd_lsr)  ls_q <= 1'b0;
      if (cto_evt)      to_q <= 1'b1;
      else if (rd_rbr)  to_q <= 1'b0;
      if (msr_chg_evt)  ms_q <= 1'b1;
      else if (rd_msr)  ms_q <= 1'b0;
    end
  end

  always_comb begin
    if (int_en[2] && ls_q)          code = 4'h6;
    else if (int_en[0] && rx_ready) code = 4'h4;
    else if (int_en[0] && to_q)     code = 4'hC;
    else if (int_en[1] && tx_q)     code = 4'h2;
    else if (int_en[3] && ms_q)     code = 4'h0;
    else                            code = 4'h1;
  end

  assign ident = {fifo_en, fifo_en, fifo_en & fifo64_en, 1'b0, code};
  assign irq   = ~code[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] int_en,
  input logic       fifo_en,
  input logic       rd_ident,
  input logic       rd_lsr,
  input logic       wr_thr,
  input logic [7:0] ident,
  input logic       irq
);
  AST_MODEM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3:0] == 4'h0 |-> int_en[3]); // R4
  AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3:0] == 4'h2 |-> int_en[1]); // R4
  AST_TX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && ident[3:0] == 4'h2) |=> ident[3:0] != 4'h2); // R6
  AST_TX_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> ident[3:0] != 4'h2); // R7
  AST_LS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ident[3:0] == 4'h6 && !rd_lsr) |=> (ident[3:0] == 4'h6 || !int_en[2])); // R9
  AST_FIFO_BITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> ident[7:4] == 4'h0); // R5
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq != ident[0]); // R12
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (.*);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] int_en = 4'h0;
  logic       lsr_err_evt = 1'b0, rx_ready = 1'b0, cto_evt = 1'b0;
  logic       thr_empty = 1'b0, msr_chg_evt = 1'b0;
  logic       fifo_en = 1'b0, fifo64_en = 1'b0;
  logic       rd_ident = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic [7:0] ident;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .lsr_err_evt(lsr_err_evt),
    .rx_ready(rx_ready), .cto_evt(cto_evt), .thr_empty(thr_empty),
    .msr_chg_evt(msr_chg_evt), .fifo_en(fifo_en), .fifo64_en(fifo64_en),
    .rd_ident(rd_ident), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
    .wr_thr(wr_thr), .ident(ident), .irq(irq));

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_id(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    tick();
  endtask

  always begin
    @(negedge clk);
    #2;
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ident !== e) begin
        errors++;
        $display("FAIL %s ident actual=%02h expected=%02h", t, ident, e);
      end
      checks++;
      if (irq !== ~e[0]) begin
        errors++;
        $display("FAIL R12 irq actual=%0b expected=%0b", irq, ~e[0]);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    expect_id(8'h01, "R1 reset idle");

    thr_empty = 1'b1; tick();
    expect_id(8'h01, "R4 tx masked");
    int_en = 4'b0010; tick();
    expect_id(8'h02, "R6 tx armed");
    rd_ident = 1'b1; tick(); rd_ident = 1'b0;
    expect_id(8'h01, "R6 read clears tx");

    int_en = 4'b0000; tick();
    int_en = 4'b0010; tick();
    expect_id(8'h02, "R2 tx rearmed");
    wr_thr = 1'b1; tick(); wr_thr = 1'b0;
    expect_id(8'h01, "R7 write clears tx");

    int_en = 4'b0000;
    msr_chg_evt = 1'b1; tick(); msr_chg_evt = 1'b0;
    expect_id(8'h01, "R4 modem masked");
    int_en = 4'b1000; tick();
    expect_id(8'h00, "R11 modem held");
    rd_ident = 1'b1; tick(); rd_ident = 1'b0;
    expect_id(8'h00, "R11 ident read keeps modem");
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    expect_id(8'h01, "R11 modem cleared");

    int_en = 4'b1111;
    thr_empty = 1'b0; tick();
    thr_empty = 1'b1; tick();
    msr_chg_evt = 1'b1; tick(); msr_chg_evt = 1'b0;
    expect_id(8'h02, "R3 tx over modem");
    rx_ready = 1'b1; tick();
    expect_id(8'h04, "R3 rx over tx");
    cto_evt = 1'b1; tick(); cto_evt = 1'b0;
    expect_id(8'h04, "R3 rx over timeout");
    lsr_err_evt = 1'b1; tick(); lsr_err_evt = 1'b0;
    expect_id(8'h06, "R3 line status first");
    tick(); tick();
    expect_id(8'h06, "R9 line status held");
    rd_ident = 1'b1; tick(); rd_ident = 1'b0;
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    expect_id(8'h04, "R9 lsr read clears");
    rx_ready = 1'b0; tick();
    expect_id(8'h0C, "R10 timeout held");
    rd_rbr = 1'b1; tick(); rd_rbr = 1'b0;
    expect_id(8'h02, "R8 tx survived ident read");
    rd_ident = 1'b1; tick(); rd_ident = 1'b0;
    expect_id(8'h00, "R6 tx cleared modem shown");
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    expect_id(8'h01, "R2 all clear");

    fifo_en = 1'b1; tick();
    expect_id(8'hC1, "R5 fifo bits");
    fifo64_en = 1'b1; tick();
    expect_id(8'hE1, "R5 fifo64 bit");
    fifo_en = 1'b0; tick();
    expect_id(8'h01, "R5 fifo64 alone");

    int_en = 4'b1010;
    lsr_err_evt = 1'b1; cto_evt = 1'b1; tick();
    lsr_err_evt = 1'b0; cto_evt = 1'b0; rx_ready = 1'b1; tick();
    expect_id(8'h01, "R4 line status and rx masked");
    rd_lsr = 1'b1; rd_rbr = 1'b1; tick(); rd_lsr = 1'b0; rd_rbr = 1'b0;
    rx_ready = 1'b0;
    int_en = 4'b1111; tick();
    expect_id(8'h01, "R4 cleared while masked");

    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule